// File: doc/BRIEF.md
# Dual Event Counter with Snapshot Registers

This block is a small performance-monitoring unit with two independent counters. Each counter watches one line of a wide bank of single-cycle event pulses, picked by a select code held in a configuration register. Software drives the unit over a simple word-addressed register bus. A single control write can clear the counters, start them, stop them, or copy their live values into snapshot registers.

Reads never see the live counters. The count registers return the low word of the snapshot. The snapshot bits above that word are returned in per-counter upper fields of the configuration register. Software therefore stops the counters and captures them in one write, then reads the upper field and the low word and joins them as `(upper << LO_W) | low`. The counters are `CNT_W` bits wide (40 by default), and the low word is `LO_W` bits wide (32 by default).

Top module: `pmu_dual_counter`

## Requirements
- R1: After reset, both live counters, both snapshots, both select fields and the run flag are zero. Every register reads back 0.
- R2: Each counter adds one in each cycle in which it is running and the event input indexed by its select code is high. A select code of 0 counts nothing, whatever `events_i[0]` does.
- R3: Control bit 0 (run) is sampled on a control write. When it is set, counting starts from the next cycle. When it is clear, both counters hold their value.
- R4: Control bit 2 (clear) zeroes both live counters in the write cycle, and that cycle's event is dropped. Writing 0x5 therefore clears the counters and then starts them.
- R5: Control bit 1 (capture) copies each live value, as it stood before the write cycle's update, into that counter's snapshot. Writing 0x2 halts counting and captures the counts in one access.
- R6: Address 2 reads the low `LO_W` bits of the counter 0 snapshot, and address 3 does the same for counter 1, zero-extended to 32 bits. The configuration word holds select 0 in bits [6:0], select 1 in bits [14:8], the counter 0 snapshot upper bits from bit 16, and the counter 1 snapshot upper bits from bit 24.
- R7: A snapshot changes only on a capture write. It stays fixed while the live counter keeps running.
- R8: A counter that passes its maximum value wraps silently to zero.
- R9: Word addresses are 0 for configuration, 1 for control (reads back the run flag in bit 0), 2 for count 0 and 3 for count 1. Read data appears on `rdata_o` at the clock edge that samples `rd_en_i`. A configuration write changes only the two select fields.
- R10: Select code 40 picks `events_i[40]` (received messages), and code 104 picks `events_i[104]` (posted requests sent).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| events_i | input | NUM_EVT (128) | Single-cycle event pulses |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 2 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered |

## Verification
The bench keeps `NUM_EVT` at 128, so that codes 40, 104 and the top code 127 are real lines. It narrows the counters to `CNT_W` = 12 with `LO_W` = 8. This places the upper field at four bits and the wrap point at 4096 events. Both the split read of a count above the low word and a full wrap then fit in a few thousand cycles, and neither could be reached at 40 bits.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int NUM_CTR = 2;
  localparam int LANE_W  = 8;
  localparam int BUS_W   = 32;

  typedef enum logic [1:0] {
    ADDR_CFG  = 2'd0,
    ADDR_CTRL = 2'd1,
    ADDR_CNT0 = 2'd2,
    ADDR_CNT1 = 2'd3
  } reg_addr_e;

  localparam int CTRL_RUN  = 0;
  localparam int CTRL_SNAP = 1;
  localparam int CTRL_CLR  = 2;
endpackage

// File: rtl/pmu_evt_sel.sv
module pmu_evt_sel #(
  parameter int NUM_EVT = 128,
  localparam int SEL_W  = $clog2(NUM_EVT)
) (
  input  logic [NUM_EVT-1:0] events_i,
  input  logic [SEL_W-1:0]   sel_i,
  output logic               hit_o
);
  // code 0 is reserved for "no event"
  assign hit_o = (sel_i != '0) && events_i[sel_i];
endmodule

// File: rtl/pmu_counter.sv
module pmu_counter #(
  parameter int CNT_W = 40
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             clr_i,
  input  logic             snap_i,
  input  logic             hit_i,
  output logic [CNT_W-1:0] shadow_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] shadow_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clr_i)           cnt_q <= '0;
    else if (run_i && hit_i)  cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     shadow_q <= '0;
    else if (snap_i) shadow_q <= cnt_q;
  end

  assign shadow_o = shadow_q;

  // R3
  hold_when_stopped_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !clr_i) |=> cnt_q == $past(cnt_q));
  // R4
  clear_zeroes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0);
  // R8
  step_by_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && hit_i && !clr_i) |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));
  // R5
  capture_live_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snap_i |=> shadow_q == $past(cnt_q));
  // R7
  shadow_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !snap_i |=> $stable(shadow_q));
endmodule

// File: rtl/pmu_dual_counter.sv
module pmu_dual_counter
  import pmu_pkg::*;
#(
  parameter int NUM_EVT = 128,
  parameter int CNT_W   = 40,
  parameter int LO_W    = 32,
  localparam int SEL_W  = $clog2(NUM_EVT),
  localparam int UP_W   = CNT_W - LO_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EVT-1:0] events_i,
  input  logic               wr_en_i,
  input  logic               rd_en_i,
  input  logic [1:0]         addr_i,
  input  logic [31:0]        wdata_i,
  output logic [31:0]        rdata_o
);
  logic [SEL_W-1:0] sel_q [NUM_CTR];
  logic             run_q;
  logic [CNT_W-1:0] shadow [NUM_CTR];
  logic             wr_cfg, wr_ctrl, clr, snap;
  logic [31:0]      cfg_word, rd_d, rdata_q;

  assign wr_cfg  = wr_en_i && (addr_i == ADDR_CFG);
  assign wr_ctrl = wr_en_i && (addr_i == ADDR_CTRL);
  assign clr     = wr_ctrl && wdata_i[CTRL_CLR];
  assign snap    = wr_ctrl && wdata_i[CTRL_SNAP];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      run_q <= 1'b0;
    else if (wr_ctrl) run_q <= wdata_i[CTRL_RUN];
  end

  for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
    logic hit;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     sel_q[g] <= '0;
      else if (wr_cfg) sel_q[g] <= wdata_i[g*LANE_W +: SEL_W];
    end

    pmu_evt_sel #(.NUM_EVT(NUM_EVT)) u_sel (
      .events_i (events_i),
      .sel_i    (sel_q[g]),
      .hit_o    (hit)
    );

    pmu_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .run_i    (run_q),
      .clr_i    (clr),
      .snap_i   (snap),
      .hit_i    (hit),
      .shadow_o (shadow[g])
    );
  end

  always_comb begin
    cfg_word = '0;
    for (int g = 0; g < NUM_CTR; g++) begin
      cfg_word[g*LANE_W +: SEL_W]             = sel_q[g];
      cfg_word[(g+NUM_CTR)*LANE_W +: UP_W]    = shadow[g][CNT_W-1:LO_W];
    end
  end

  always_comb begin
    unique case (addr_i)
      ADDR_CFG:  rd_d = cfg_word;
      ADDR_CTRL: rd_d = {31'd0, run_q};
      ADDR_CNT0: rd_d = 32'(shadow[0][LO_W-1:0]);
      default:   rd_d = 32'(shadow[1][LO_W-1:0]);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_d;
  end

  assign rdata_o = rdata_q;

  logic unused_wdata;
  assign unused_wdata = ^{wdata_i[31:16], wdata_i[7], wdata_i[15], wdata_i[3]};

  // R9
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o));
  // R3
  run_follows_ctrl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_ctrl |=> run_q == $past(run_q));
endmodule

// File: tb/pmu_dual_counter_bench.sv
`timescale 1ns/1ps
module pmu_dual_counter_bench;
  localparam int NUM_EVT = 128;
  localparam int CNT_W   = 12;
  localparam int LO_W    = 8;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [NUM_EVT-1:0] events = '0;
  logic               wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0]         addr = '0;
  logic [31:0]        wdata = '0;
  logic [31:0]        rdata;
  int n_chk = 0, n_fail = 0, cyc = 0;

  always #2 clk = ~clk;

  pmu_dual_counter #(.NUM_EVT(NUM_EVT), .CNT_W(CNT_W), .LO_W(LO_W)) u_pmu_dual_counter (
    .clk_i(clk), .rst_ni(rst_n), .events_i(events), .wr_en_i(wr_en),
    .rd_en_i(rd_en), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata));

  // sel0, sel1, every-cycle bit, even-cycle bit, cycles, exp0, exp1
  localparam int VEC [5][7] = '{
    '{ 40, 104,  40, 104, 10, 10, 5},
    '{104,  40,  40, 104,  7,  4, 7},
    '{  0,   3,   3,   0,  6,  0, 6},
    '{127, 126, 127,   5,  9,  9, 0},
    '{  5,   5,   5,   5,  8,  8, 8}
  };

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic check(string req, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input int d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic pulse(input int every_bit, input int even_bit, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      events = '0;
      events[every_bit] = 1'b1;
      if (i % 2 == 0) events[even_bit] = 1'b1;
    end
    @(negedge clk); events = '0;
  endtask

  initial begin
    int d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d); check("R1 reset read", d, 0);
    end

    // R9 config readback, R2/R10 vector walk
    wr(2'd0, 40 | (104 << 8));
    rd(2'd0, d); check("R9 cfg readback", d, 40 | (104 << 8));
    for (int v = 0; v < 5; v++) begin
      wr(2'd0, VEC[v][0] | (VEC[v][1] << 8));
      wr(2'd1, 5);
      pulse(VEC[v][2], VEC[v][3], VEC[v][4]);
      wr(2'd1, 2);
      rd(2'd2, d); check("R2/R10 count0", d, VEC[v][5]);
      rd(2'd3, d); check("R2/R10 count1", d, VEC[v][6]);
    end

    // R3 run/halt, control readback
    wr(2'd0, 40);
    wr(2'd1, 5);
    rd(2'd1, d); check("R9 ctrl run flag", d, 1);
    pulse(40, 40, 5);
    wr(2'd1, 0);
    pulse(40, 40, 5);
    wr(2'd1, 2);
    rd(2'd2, d); check("R3 halted count", d, 5);

    // R4 clear without start
    wr(2'd1, 4);
    pulse(40, 40, 3);
    wr(2'd1, 2);
    rd(2'd2, d); check("R4 cleared count", d, 0);

    // R7 snapshot stays fixed while running, R5 capture
    wr(2'd1, 5);
    pulse(40, 40, 3);
    wr(2'd1, 3);
    pulse(40, 40, 4);
    rd(2'd2, d); check("R7 shadow stable", d, 3);
    wr(2'd1, 2);
    rd(2'd2, d); check("R5 capture after run", d, 7);

    // R6 split read above the low word
    wr(2'd1, 5);
    pulse(40, 40, 260);
    wr(2'd1, 2);
    rd(2'd2, d); check("R6 low word", d, 4);
    rd(2'd0, d); check("R6 upper field", (d >> 16) & 'hF, 1);
    check("R6 joined count", (((d >> 16) & 'hF) << LO_W) | 4, 260);
    check("R9 cfg write keeps sel", d & 'hFFFF, 40);

    // R8 wrap
    wr(2'd1, 5);
    pulse(40, 40, 4099);
    wr(2'd1, 2);
    rd(2'd2, d); check("R8 wrapped low", d, 3);
    rd(2'd0, d); check("R8 wrapped upper", (d >> 16) & 'hF, 0);
    rd(2'd3, d); check("R2 unselected counter", d, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule